// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) keeps its operands correct and its instruction stream on the right path. It looks at the two source register indices of the instruction in decode and at the destination index, write enable and load flag of the older instructions in execute and memory. From these it produces, for each ALU operand, a bypass select. The pipeline captures these selects into the decode/execute register along with the instruction, and applies them when the instruction reaches execute.

The register file completes its write before its read in the same cycle. A producer that has reached writeback therefore hands its value to decode through the register file, so the writeback stage needs neither a bypass path nor an input here. ALU results, including the return address written by jump-and-link instructions, are bypassed with no lost cycle. The one stall comes from a load followed immediately by a consumer of its result: the program counter and the fetch/decode register hold for one cycle while a bubble enters execute.

Branch and jump outcomes are resolved in execute and redirect fetch there. When a transfer is taken, the two younger instructions already fetched are squashed. A squash wins over a load-use stall raised in the same cycle, because the stalled instruction is on the wrong path anyway. The block is purely combinational.

Top module: `hazard_unit`

## Requirements
- R1: Operand select encoding is 0 = register file value, 1 = memory/writeback bypass, 2 = execute/memory bypass; the value 3 is never produced.
- R2: When the instruction in execute writes a nonzero register equal to a decode source, that operand's select is 2.
- R3: When the instruction in memory writes a nonzero register equal to a decode source and the instruction in execute does not, that operand's select is 1.
- R4: When both the execute and memory instructions write the register a source names, the select is 2 (the youngest producer wins).
- R5: A destination of register 0 never causes a bypass select or a stall, even for a load.
- R6: A producer whose write enable is low never causes a bypass select or a stall.
- R7: A load in execute whose nonzero destination matches either decode source, with no taken transfer, raises the hold output and the execute-bubble output and leaves the fetch/decode squash low.
- R8: A load in memory matching a decode source yields select 1 and no stall.
- R9: A taken transfer raises both the fetch/decode squash and the execute-bubble outputs and forces hold low, even when a load-use condition is present.
- R10: With no matching producer and no taken transfer, both selects are 0 and all three control outputs are low.
- R11: Each operand's select depends only on its own source index; the two are decided independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes its destination |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes its destination |
| ex_taken | input | 1 | Branch or jump in execute is taken |
| fwd_a | output | 2 | Bypass select for ALU operand A |
| fwd_b | output | 2 | Bypass select for ALU operand B |
| hold_fetch | output | 1 | Hold the PC and the fetch/decode register |
| squash_ifid | output | 1 | Turn the fetch/decode instruction into a bubble |
| squash_idex | output | 1 | Put a bubble into the decode/execute register |

## Verification
The bench sweeps every combination of a four-register subset of indices, both write enables, the load flag and the taken input. This exercises the register 0 destination, where a design that compared indices without excluding zero would bypass a hardwired zero or stall on it. It covers a load that matches only the second source, where a design checking one source would let a stale operand through. It also covers a load that matches while a transfer is taken, where giving the stall priority would freeze fetch on the wrong path and lose the redirect. The same-register double-producer case catches a priority swap that would hand the consumer an older value. Named sequences for a dependency two apart, and for one three apart that resolves through the register file, confirm that no select is raised for the latter.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              ex_taken,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              hold_fetch,
  output logic              squash_ifid,
  output logic              squash_idex
);
  localparam logic [1:0] SEL_RF  = 2'd0;
  localparam logic [1:0] SEL_MEM = 2'd1;
  localparam logic [1:0] SEL_EX  = 2'd2;
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic ex_live, mem_live, ex_hit_a, ex_hit_b, load_use;

  assign ex_live  = ex_wen  && (ex_rd  != ZERO_REG);
  assign mem_live = mem_wen && (mem_rd != ZERO_REG);
  assign ex_hit_a = ex_live && (ex_rd == id_rs1);
  assign ex_hit_b = ex_live && (ex_rd == id_rs2);

  assign fwd_a = ex_hit_a ? SEL_EX :
                 (mem_live && mem_rd == id_rs1) ? SEL_MEM : SEL_RF;
  assign fwd_b = ex_hit_b ? SEL_EX :
                 (mem_live && mem_rd == id_rs2) ? SEL_MEM : SEL_RF;

  assign load_use    = ex_load && (ex_hit_a || ex_hit_b);
  assign hold_fetch  = load_use && !ex_taken;
  assign squash_ifid = ex_taken;
  assign squash_idex = ex_taken || load_use;
endmodule

module hazard_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_wen,
  input logic              ex_load,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_wen,
  input logic              ex_taken,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              hold_fetch,
  input logic              squash_ifid,
  input logic              squash_idex
);
  logic known;
  assign known = !$isunknown({id_rs1, id_rs2, ex_rd, ex_wen, ex_load, mem_rd,
                              mem_wen, ex_taken, fwd_a, fwd_b, hold_fetch,
                              squash_ifid, squash_idex});

  always_comb begin
    if (known) begin
      AST_SEL_LEGAL: assert (fwd_a != 2'd3 && fwd_b != 2'd3); // R1
      AST_X0_QUIET: assert (!(ex_rd == '0 && mem_rd == '0) ||
                            (fwd_a == 2'd0 && fwd_b == 2'd0 && !hold_fetch)); // R5
      AST_NOWRITE_QUIET: assert (ex_wen || mem_wen ||
                                 (fwd_a == 2'd0 && fwd_b == 2'd0 && !hold_fetch)); // R6
      AST_HOLD_BUBBLE: assert (!hold_fetch || (squash_idex && !squash_ifid)); // R7
      AST_HOLD_NEEDS_LOAD: assert (!hold_fetch || (ex_load && (fwd_a == 2'd2 || fwd_b == 2'd2))); // R7
      AST_TAKEN_SQUASH: assert (!ex_taken || (squash_ifid && squash_idex && !hold_fetch)); // R9
      AST_MEM_NO_STALL: assert (!(!ex_wen && !ex_taken) ||
                                (!hold_fetch && !squash_idex && !squash_ifid)); // R8
    end
  end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_AW(REG_AW)) chk_i (
  .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
  .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen), .ex_taken(ex_taken),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_fetch(hold_fetch),
  .squash_ifid(squash_ifid), .squash_idex(squash_idex)
);

// File: tb/hazard_unit_tb_top.sv
module hazard_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REG_AW = 5;

  logic clk = 1'b0;
  logic [REG_AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic ex_wen, ex_load, mem_wen, ex_taken;
  logic [1:0] fwd_a, fwd_b;
  logic hold_fetch, squash_ifid, squash_idex;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_unit #(.REG_AW(REG_AW)) dut_i (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen), .ex_taken(ex_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_fetch(hold_fetch),
    .squash_ifid(squash_ifid), .squash_idex(squash_idex)
  );

  function automatic int exp_sel(int rs, int erd, bit ew, int mrd, bit mw);
    if (ew && erd != 0 && erd == rs) return 2;
    if (mw && mrd != 0 && mrd == rs) return 1;
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (rs1=%0d rs2=%0d exrd=%0d ew=%0b ld=%0b memrd=%0d mw=%0b tk=%0b)",
               tag, what, act, exp, id_rs1, id_rs2, ex_rd, ex_wen, ex_load,
               mem_rd, mem_wen, ex_taken);
    end
  endtask

  task automatic apply(int r1, int r2, int erd, bit ew, bit ld, int mrd, bit mw, bit tk);
    @(posedge clk);
    id_rs1 = REG_AW'(r1); id_rs2 = REG_AW'(r2); ex_rd = REG_AW'(erd);
    ex_wen = ew; ex_load = ld; mem_rd = REG_AW'(mrd); mem_wen = mw; ex_taken = tk;
    @(negedge clk);
  endtask

  task automatic verify(string tag);
    int ea, eb;
    bit lu;
    ea = exp_sel(int'(id_rs1), int'(ex_rd), ex_wen, int'(mem_rd), mem_wen);
    eb = exp_sel(int'(id_rs2), int'(ex_rd), ex_wen, int'(mem_rd), mem_wen);
    lu = ex_load && ex_wen && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    check(tag, "fwd_a", int'(fwd_a), ea);
    check(tag, "fwd_b", int'(fwd_b), eb);
    check(tag, "hold_fetch", int'(hold_fetch), int'(lu && !ex_taken));
    check(tag, "squash_ifid", int'(squash_ifid), int'(ex_taken));
    check(tag, "squash_idex", int'(squash_idex), int'(lu || ex_taken));
  endtask

  function automatic string pick_tag(int r1, int r2, int erd, bit ew, bit ld, int mrd, bit mw, bit tk);
    bit eh, mh;
    eh = ew && erd != 0 && (erd == r1 || erd == r2);
    mh = mw && mrd != 0 && (mrd == r1 || mrd == r2);
    if (tk) return "R9";
    if (erd == 0 && mrd == 0 && (ew || mw)) return "R5";
    if (!ew && !mw) return "R6";
    if (eh && ld) return "R7";
    if (eh && mh && erd == mrd) return "R4";
    if (eh) return "R2";
    if (mh) return "R3";
    if (r1 != r2) return "R11";
    return "R10";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    verify("R10");
    check("R1", "idle sel a", int'(fwd_a), 0);

    // back-to-back ALU dependency: add x5 then sub uses x5
    apply(5, 6, 5, 1, 0, 0, 0, 0);  verify("R2");
    // dependency two apart
    apply(7, 5, 9, 1, 0, 5, 1, 0);  verify("R3");
    check("R11", "rs2 from mem", int'(fwd_b), 1);
    // three apart: writeback, resolved through register file
    apply(5, 5, 9, 1, 0, 8, 1, 0);  verify("R10");
    // same register twice in flight
    apply(3, 3, 3, 1, 0, 3, 1, 0);  verify("R4");
    check("R4", "youngest a", int'(fwd_a), 2);
    // load-use on rs2 only
    apply(1, 4, 4, 1, 1, 0, 0, 0);  verify("R7");
    check("R7", "hold on rs2 match", int'(hold_fetch), 1);
    // load now in memory: bypass, no stall
    apply(1, 4, 0, 0, 0, 4, 1, 0);  verify("R8");
    check("R8", "load in mem sel b", int'(fwd_b), 1);
    // load to x0
    apply(0, 0, 0, 1, 1, 0, 1, 0);  verify("R5");
    check("R5", "x0 load no hold", int'(hold_fetch), 0);
    // taken branch with load-use present
    apply(2, 2, 2, 1, 1, 0, 0, 1);  verify("R9");
    check("R9", "flush wins hold", int'(hold_fetch), 0);
    // jump-and-link return address consumed next
    apply(1, 0, 1, 1, 0, 0, 0, 1);  verify("R9");
    check("R2", "link bypass", int'(fwd_a), 2);

    for (int r1 = 0; r1 < 4; r1++)
      for (int r2 = 0; r2 < 4; r2++)
        for (int erd = 0; erd < 4; erd++)
          for (int mrd = 0; mrd < 4; mrd++)
            for (int fl = 0; fl < 16; fl++) begin
              apply(r1, r2, erd, fl[0], fl[1], mrd, fl[2], fl[3]);
              verify(pick_tag(r1, r2, erd, fl[0], fl[1], mrd, fl[2], fl[3]));
            end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule